// File: doc/BRIEF.md
# Interrupt Acknowledge Context Capture

This block is the interrupt-service front end of a two-channel serial peripheral. A built-in arbiter watches four interrupt sources per channel (receive, transmit, line status, modem change), each with its own pending flag and priority level, and picks a single winner whose level is above a programmed threshold. When the host runs an interrupt-acknowledge cycle, or writes the update command, the winner is frozen into a current-interrupt register. That register then holds until the next acknowledge or update, even if the sources change in the meantime.

The acknowledge cycle behaves as a special read. While it is active the data bus carries an interrupt vector, which is a fixed constant, the programmed vector register, or the vector register with its low bits replaced by the captured type and channel codes. The captured channel and type also form a context that steers two fixed-address global registers. One returns the byte count of the matching receive or transmit FIFO. The other reads from the captured channel's receive FIFO port or writes to its transmit FIFO port. The FIFOs themselves are outside the block.

Top module: `irq_ctx_capture`

## Requirements
- R1: The current-interrupt register (bus address 3, read) loads only on the first clock edge where `iack` is high after being low, or on an update command. It keeps its value otherwise, including while `iack` stays high and the sources change.
- R2: A bus write of any data to address 3 is the update command: it loads the current-interrupt register exactly as an acknowledge does.
- R3: The captured byte is {channel in bit 7, type in bits 6:4, level in bits 3:0}. The type codes are 1 receive, 2 transmit, 3 line status and 4 modem change. If no pending source has a level strictly above the threshold (address 2, bits 3:0), the register loads 8'h00.
- R4: The arbiter picks the pending source with the highest level. A tie goes to the lower channel, and then to the lower type code.
- R5: While `iack` is high, `bus_rdata` carries the vector, which reflects the captured value from the cycle after the acknowledge edge. Vector mode 0 (address 0, bits 1:0) gives the fixed vector 8'h0F.
- R6: Mode 1 gives the vector register (address 1). Mode 2 gives {vector[7:3], type}. Mode 3 gives {vector[7:4], channel, type}.
- R7: In modes 2 and 3, a zero capture makes every replaced vector bit zero.
- R8: A read of address 4 returns the receive byte count of the captured channel when the type is 1, the transmit count when the type is 2, and 0 for any other type.
- R9: A read of address 5 returns the captured channel's receive data and raises only that channel's `rx_pop` bit, but only when the captured type is non-zero. When the type is zero, no pop occurs.
- R10: A write to address 5 raises only the captured channel's `tx_push` bit and presents the write data on `tx_wdata`, but only when the captured type is non-zero. When the type is zero, no push occurs.
- R11: After reset, the mode, vector, threshold and current-interrupt registers all read 0. The mode, vector and threshold registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iack | input | 1 | Interrupt acknowledge, level; its rise captures |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or vector while `iack` is high |
| src_pend | input | NUM_CH*4 | Pending flags, index channel*4 + type-1 |
| src_prio | input | NUM_CH*16 | 4-bit level per source, same index |
| rx_cnt | input | NUM_CH*CNT_W | Receive FIFO byte counts |
| tx_cnt | input | NUM_CH*CNT_W | Transmit FIFO byte counts |
| rx_data | input | NUM_CH*8 | Receive FIFO head bytes |
| rx_pop | output | NUM_CH | Receive FIFO pop strobes |
| tx_push | output | NUM_CH | Transmit FIFO push strobes |
| tx_wdata | output | 8 | Transmit FIFO write byte |

## Verification
Assertions check the following on every cycle: the held register stays still whenever there is neither an acknowledge rise nor an update, a zero type comes with an all-zero capture, the FIFO strobes are at most one-hot and silent with no context, and the modified vector bits are zero for an empty capture. The arbitration order, the exact vector values in each mode, the count selection and the data routing to the right channel depend on chosen source patterns. Only the bench's table of arbitration cases and its directed scenarios can show those.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
   localparam int DATA_W  = 8;
   localparam int TYPE_W  = 3;
   localparam int LVL_W   = 4;
   localparam int ADDR_W  = 3;

   typedef enum logic [TYPE_W-1:0] {
      IT_NONE  = 3'd0,
      IT_RX    = 3'd1,
      IT_TX    = 3'd2,
      IT_LINE  = 3'd3,
      IT_MODEM = 3'd4
   } irq_type_e;

   typedef enum logic [1:0] {
      VM_FIXED  = 2'd0,
      VM_PROG   = 2'd1,
      VM_TYPE   = 2'd2,
      VM_TYPECH = 2'd3
   } vec_mode_e;

   localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
   localparam logic [ADDR_W-1:0] A_VEC   = 3'd1;
   localparam logic [ADDR_W-1:0] A_THR   = 3'd2;
   localparam logic [ADDR_W-1:0] A_CTX   = 3'd3;
   localparam logic [ADDR_W-1:0] A_GCNT  = 3'd4;
   localparam logic [ADDR_W-1:0] A_GFIFO = 3'd5;

   typedef struct packed {
      logic                 ch;
      logic [TYPE_W-1:0]    typ;
      logic [LVL_W-1:0]     lvl;
   } ctx_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_ctx_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int NUM_TYPES = 4
) (
   input  logic [NUM_CH*NUM_TYPES-1:0]       pend,
   input  logic [NUM_CH*NUM_TYPES*LVL_W-1:0] lvl,
   input  logic [LVL_W-1:0]                  thresh,
   output ctx_t                              win
);
   localparam int NSRC = NUM_CH * NUM_TYPES;

   logic [LVL_W-1:0]  best_lvl;
   logic              best_ch;
   logic [TYPE_W-1:0] best_typ;
   logic              found;

   always_comb begin
      best_lvl = thresh;
      best_ch  = 1'b0;
      best_typ = '0;
      found    = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
         if (pend[s] && (lvl[s*LVL_W +: LVL_W] > best_lvl)) begin
            found    = 1'b1;
            best_lvl = lvl[s*LVL_W +: LVL_W];
            best_ch  = (s >= NUM_TYPES);
            best_typ = TYPE_W'((s % NUM_TYPES) + 1);
         end
      end
      if (found) begin
         win = '{ch: best_ch, typ: best_typ, lvl: best_lvl};
      end else begin
         win = '0;
      end
   end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
   import irq_ctx_pkg::*;
#(
   parameter logic [DATA_W-1:0] FIXED_VEC = 8'h0F,
   parameter bit                ALLOW_MOD = 1'b1
) (
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] prog_vec,
   input  logic              ctx_ch,
   input  logic [TYPE_W-1:0] ctx_typ,
   output logic [DATA_W-1:0] vec
);
   generate
      if (ALLOW_MOD) begin : g_mod
         always_comb begin
            unique case (vec_mode_e'(mode))
               VM_FIXED:  vec = FIXED_VEC;
               VM_PROG:   vec = prog_vec;
               VM_TYPE:   vec = {prog_vec[DATA_W-1:TYPE_W], ctx_typ};
               VM_TYPECH: vec = {prog_vec[DATA_W-1:TYPE_W+1], ctx_ch, ctx_typ};
               default:   vec = FIXED_VEC;
            endcase
         end
      end else begin : g_plain
         logic unused_ctx;
         assign unused_ctx = ctx_ch ^ (^ctx_typ);
         assign vec = (mode == 2'd0) ? FIXED_VEC : prog_vec;
      end
   endgenerate
endmodule

// File: rtl/irq_ctx_route.sv
module irq_ctx_route
   import irq_ctx_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 8
) (
   input  logic                     ctx_ch,
   input  logic [TYPE_W-1:0]        ctx_typ,
   input  logic [NUM_CH*CNT_W-1:0]  rx_cnt,
   input  logic [NUM_CH*CNT_W-1:0]  tx_cnt,
   input  logic [NUM_CH*DATA_W-1:0] rx_data,
   input  logic                     rd_fifo,
   input  logic                     wr_fifo,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        gcnt,
   output logic [DATA_W-1:0]        gdata,
   output logic [NUM_CH-1:0]        rx_pop,
   output logic [NUM_CH-1:0]        tx_push,
   output logic [DATA_W-1:0]        tx_wdata
);
   logic live;
   assign live = (ctx_typ != IT_NONE);

   always_comb begin
      gcnt = '0;
      unique case (irq_type_e'(ctx_typ))
         IT_RX:   gcnt = DATA_W'(rx_cnt[ctx_ch*CNT_W +: CNT_W]);
         IT_TX:   gcnt = DATA_W'(tx_cnt[ctx_ch*CNT_W +: CNT_W]);
         default: gcnt = '0;
      endcase
   end

   assign gdata    = live ? rx_data[ctx_ch*DATA_W +: DATA_W] : '0;
   assign tx_wdata = wdata;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit        = live && (int'(ctx_ch) == c);
      assign rx_pop[c]  = rd_fifo && hit;
      assign tx_push[c] = wr_fifo && hit;
   end
endmodule

// File: rtl/irq_ctx_capture.sv
module irq_ctx_capture
   import irq_ctx_pkg::*;
#(
   parameter int                NUM_CH    = 2,
   parameter int                CNT_W     = 8,
   parameter logic [DATA_W-1:0] FIXED_VEC = 8'h0F,
   parameter bit                ALLOW_MOD = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         iack,
   input  logic                         bus_sel,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [NUM_CH*4-1:0]          src_pend,
   input  logic [NUM_CH*4*LVL_W-1:0]    src_prio,
   input  logic [NUM_CH*CNT_W-1:0]      rx_cnt,
   input  logic [NUM_CH*CNT_W-1:0]      tx_cnt,
   input  logic [NUM_CH*DATA_W-1:0]     rx_data,
   output logic [NUM_CH-1:0]            rx_pop,
   output logic [NUM_CH-1:0]            tx_push,
   output logic [DATA_W-1:0]            tx_wdata
);
   localparam int NUM_TYPES = 4;

   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("irq_ctx_capture: NUM_CH must be 1 or 2");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("irq_ctx_capture: CNT_W must be 1..DATA_W");
   end

   logic [1:0]        vmode_q;
   logic [DATA_W-1:0] ivec_q;
   logic [LVL_W-1:0]  thr_q;
   ctx_t              cir_q;
   logic              iack_q;

   ctx_t              win;
   logic              wr_acc, rd_acc, upd, cap;
   logic [DATA_W-1:0] vec, gcnt, gdata;

   assign wr_acc = bus_sel && bus_wr;
   assign rd_acc = bus_sel && !bus_wr && !iack;
   assign upd    = wr_acc && (bus_addr == A_CTX);
   assign cap    = (iack && !iack_q) || upd;

   irq_arbiter #(.NUM_CH(NUM_CH), .NUM_TYPES(NUM_TYPES)) u_arb (
      .pend   (src_pend),
      .lvl    (src_prio),
      .thresh (thr_q),
      .win    (win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vmode_q <= '0;
         ivec_q  <= '0;
         thr_q   <= '0;
         cir_q   <= '0;
         iack_q  <= 1'b0;
      end else begin
         iack_q <= iack;
         if (cap) cir_q <= win;
         if (wr_acc && bus_addr == A_MODE) vmode_q <= bus_wdata[1:0];
         if (wr_acc && bus_addr == A_VEC)  ivec_q  <= bus_wdata;
         if (wr_acc && bus_addr == A_THR)  thr_q   <= bus_wdata[LVL_W-1:0];
      end
   end

   irq_vector_gen #(.FIXED_VEC(FIXED_VEC), .ALLOW_MOD(ALLOW_MOD)) u_vec (
      .mode     (vmode_q),
      .prog_vec (ivec_q),
      .ctx_ch   (cir_q.ch),
      .ctx_typ  (cir_q.typ),
      .vec      (vec)
   );

   irq_ctx_route #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_route (
      .ctx_ch   (cir_q.ch),
      .ctx_typ  (cir_q.typ),
      .rx_cnt   (rx_cnt),
      .tx_cnt   (tx_cnt),
      .rx_data  (rx_data),
      .rd_fifo  (rd_acc && bus_addr == A_GFIFO),
      .wr_fifo  (wr_acc && bus_addr == A_GFIFO),
      .wdata    (bus_wdata),
      .gcnt     (gcnt),
      .gdata    (gdata),
      .rx_pop   (rx_pop),
      .tx_push  (tx_push),
      .tx_wdata (tx_wdata)
   );

   always_comb begin
      bus_rdata = '0;
      if (iack) begin
         bus_rdata = vec;
      end else if (rd_acc) begin
         unique case (bus_addr)
            A_MODE:  bus_rdata = {{(DATA_W-2){1'b0}}, vmode_q};
            A_VEC:   bus_rdata = ivec_q;
            A_THR:   bus_rdata = {{(DATA_W-LVL_W){1'b0}}, thr_q};
            A_CTX:   bus_rdata = cir_q;
            A_GCNT:  bus_rdata = gcnt;
            A_GFIFO: bus_rdata = gdata;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_ctx_capture_chk.sv
module irq_ctx_capture_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iack,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [2:0]        bus_addr,
   input logic [7:0]        bus_rdata,
   input logic [7:0]        cir,
   input logic [1:0]        vmode,
   input logic [NUM_CH-1:0] rx_pop,
   input logic [NUM_CH-1:0] tx_push
);
   logic upd_seen;
   assign upd_seen = bus_sel && bus_wr && (bus_addr == 3'd3);

   AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(iack && !$past(iack)) && !upd_seen) |=> $stable(cir)); // R1

   AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cir[6:4] == 3'd0) |-> (cir == 8'h00)); // R3

   AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cir[6:4] <= 3'd4)); // R3

   AST_VEC_EMPTY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && cir == 8'h00 && vmode[1]) |-> (bus_rdata[2:0] == 3'd0)); // R7

   AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_pop)); // R9

   AST_POP_NEEDS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      (cir[6:4] == 3'd0) |-> (rx_pop == '0)); // R9

   AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_push)); // R10

   AST_PUSH_NEEDS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
      (cir[6:4] == 3'd0) |-> (tx_push == '0)); // R10
endmodule

bind irq_ctx_capture irq_ctx_capture_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iack      (iack),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .cir       (cir_q),
   .vmode     (vmode_q),
   .rx_pop    (rx_pop),
   .tx_push   (tx_push)
);

// File: tb/irq_ctx_capture_bench.sv
module irq_ctx_capture_bench;
   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iack = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  src_pend = '0;
   logic [31:0] src_prio = '0;
   logic [15:0] rx_cnt = {8'h22, 8'h11};
   logic [15:0] tx_cnt = {8'h44, 8'h33};
   logic [15:0] rx_data = {8'hB1, 8'hA0};
   logic [1:0]  rx_pop;
   logic [1:0]  tx_push;
   logic [7:0]  tx_wdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [1:0] last_pop;
   logic [1:0] last_push;
   logic [7:0] last_txd;
   logic [7:0] rv;

   always #10 clk = ~clk;

   irq_ctx_capture u_irq_ctx_capture (
      .clk(clk), .rst_n(rst_n), .iack(iack), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_pend(src_pend), .src_prio(src_prio), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
      .rx_data(rx_data), .rx_pop(rx_pop), .tx_push(tx_push), .tx_wdata(tx_wdata)
   );

   // {pend, levels (nibble s = channel*4 + type-1), threshold, expected capture}
   localparam logic [51:0] TBL [8] = '{
      {8'h01, 32'h0000_0005, 4'd2,  8'h15},
      {8'h21, 32'h0090_0003, 4'd0,  8'hA9},
      {8'h12, 32'h0007_0070, 4'd0,  8'h27},
      {8'h0C, 32'h0000_6600, 4'd0,  8'h36},
      {8'h80, 32'h4000_0000, 4'd4,  8'h00},
      {8'h00, 32'hFFFF_FFFF, 4'd0,  8'h00},
      {8'h80, 32'hF000_0000, 4'd14, 8'hCF},
      {8'hFF, 32'hBCBB_BBBB, 4'd0,  8'hBC}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata; last_pop = rx_pop;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #2 last_push = tx_push; last_txd = tx_wdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic ack(output logic [7:0] v);
      @(negedge clk);
      iack = 1'b1;
      @(negedge clk);
      #2 v = bus_rdata;
      @(negedge clk);
      iack = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      bus_read(3'd0, rv); check("R11 mode reset", rv, 8'h00);
      bus_read(3'd1, rv); check("R11 vector reset", rv, 8'h00);
      bus_read(3'd2, rv); check("R11 threshold reset", rv, 8'h00);
      bus_read(3'd3, rv); check("R11 capture reset", rv, 8'h00);
      bus_write(3'd1, 8'hE7); bus_read(3'd1, rv); check("R11 vector readback", rv, 8'hE7);
      bus_write(3'd0, 8'h03); bus_read(3'd0, rv); check("R11 mode readback", rv, 8'h03);
      bus_write(3'd0, 8'h01);

      // R3 R4: arbitration table through acknowledge
      for (int i = 0; i < 8; i++) begin
         src_pend = TBL[i][51:44];
         src_prio = TBL[i][43:12];
         bus_write(3'd2, {4'h0, TBL[i][11:8]});
         ack(rv);
         bus_read(3'd3, rv);
         check($sformatf("R4 R3 table entry %0d", i), rv, TBL[i][7:0]);
      end

      // R2 update command
      src_pend = 8'h21; src_prio = 32'h0090_0003;
      bus_write(3'd2, 8'h00);
      bus_write(3'd3, 8'h5C);
      bus_read(3'd3, rv); check("R2 update capture", rv, 8'hA9);

      // R1 hold while iack stays high and sources change
      bus_write(3'd0, 8'h03);
      @(negedge clk); iack = 1'b1;
      @(negedge clk); #2 check("R1 vector after edge", bus_rdata, 8'hEA);
      src_pend = 8'h01; src_prio = 32'h0000_0005;
      repeat (3) @(negedge clk);
      #2 check("R1 held during iack", bus_rdata, 8'hEA);
      iack = 1'b0;
      bus_read(3'd3, rv); check("R1 held after iack", rv, 8'hA9);
      bus_read(3'd3, rv); check("R1 held without event", rv, 8'hA9);

      // R5 R6 vector modes, capture ch1 transmit level 9
      src_pend = 8'h21; src_prio = 32'h0090_0003;
      bus_write(3'd0, 8'h00); ack(rv); check("R5 fixed vector", rv, 8'h0F);
      bus_write(3'd0, 8'h01); ack(rv); check("R6 programmed vector", rv, 8'hE7);
      bus_write(3'd0, 8'h02); ack(rv); check("R6 type-modified vector", rv, 8'hE2);
      bus_write(3'd0, 8'h03); ack(rv); check("R6 type+channel vector", rv, 8'hEA);

      // R8 count context: transmit of ch1
      bus_read(3'd4, rv); check("R8 tx count ch1", rv, 8'h44);

      // R7 empty capture with modified vector
      src_pend = 8'h00;
      ack(rv); check("R7 empty type+channel vector", rv, 8'hE0);
      bus_write(3'd0, 8'h02); ack(rv); check("R7 empty type vector", rv, 8'hE0);

      // R9 R10 no routing with empty context
      bus_read(3'd5, rv); check("R9 no pop when empty", {6'd0, last_pop}, 8'h00);
      bus_write(3'd5, 8'h66); check("R10 no push when empty", {6'd0, last_push}, 8'h00);
      bus_read(3'd4, rv); check("R8 empty count", rv, 8'h00);

      // R8 receive of ch0
      src_pend = 8'h01; src_prio = 32'h0000_0005;
      ack(rv); bus_read(3'd4, rv); check("R8 rx count ch0", rv, 8'h11);

      // R8 line status context gives zero
      src_pend = 8'hFF; src_prio = 32'hBCBB_BBBB;
      ack(rv); bus_read(3'd4, rv); check("R8 line status count", rv, 8'h00);

      // R8 R9 R10 receive of ch1
      src_pend = 8'h10; src_prio = 32'h0001_0000;
      ack(rv);
      bus_read(3'd4, rv); check("R8 rx count ch1", rv, 8'h22);
      bus_read(3'd5, rv); check("R9 rx data ch1", rv, 8'hB1);
      check("R9 pop ch1 only", {6'd0, last_pop}, 8'h02);
      bus_write(3'd5, 8'h77);
      check("R10 push ch1 only", {6'd0, last_push}, 8'h02);
      check("R10 push data", last_txd, 8'h77);

      // R9 R10 channel 0 context
      src_pend = 8'h02; src_prio = 32'h0000_0030;
      ack(rv);
      bus_read(3'd5, rv); check("R9 rx data ch0", rv, 8'hA0);
      check("R9 pop ch0 only", {6'd0, last_pop}, 8'h01);
      bus_write(3'd5, 8'h3C);
      check("R10 push ch0 only", {6'd0, last_push}, 8'h01);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule